// File: doc/BRIEF.md
# Arithmetic ALU Slice with Shared T Flag

This block is the integer slice of a 32-bit core's execute stage that handles a small group of arithmetic instructions: decrement-and-test, byte and word widening (signed and unsigned), negate, negate with borrow, subtract and subtract with borrow. Each cycle it takes a 16-bit instruction word, the two source register values (`rm_i`, `rn_i`) and the current T flag. It returns the value to be written back to the destination register, the new T value, and a write-enable for each.

T does two jobs. The borrow-chained operations read it as an incoming borrow and write the outgoing borrow back to it. Decrement-and-test writes a zero-test result to it. The remaining operations leave it alone. Every operation takes one state, and all outputs are registered once. An instruction word outside the group asserts an illegal-instruction flag and writes nothing.

Top module: `tflag_alu`

## Requirements
- R1: Every output reflects the inputs sampled at the previous rising clock edge, so there is exactly one cycle of latency, for every opcode.
- R2: `0100nnnn00010000` writes rn-1 with rn_we_o=1 and t_we_o=1. t_o is 1 when the new value is zero and 0 otherwise.
- R3: `0110nnnnmmmm1110` writes the low byte of rm sign-extended to 32 bits. `0110nnnnmmmm1111` writes the low 16 bits of rm sign-extended. Neither writes T.
- R4: `0110nnnnmmmm1100` writes the low byte of rm zero-extended. `0110nnnnmmmm1101` writes the low 16 bits of rm zero-extended. Neither writes T.
- R5: `0110nnnnmmmm1011` writes 0-rm with t_we_o=0.
- R6: `0110nnnnmmmm1010` writes 0-rm-T with t_we_o=1. t_o is the borrow, meaning the unsigned underflow of the 33-bit subtraction.
- R7: `0011nnnnmmmm1000` writes rn-rm with t_we_o=0.
- R8: `0011nnnnmmmm1010` writes rn-rm-T with t_we_o=1. t_o is the unsigned borrow out.
- R9: Any other instruction word sets illegal_o=1, rn_we_o=0, t_we_o=0 and rn_o=0.
- R10: While rst_ni is low, every output is 0, asynchronously.
- R11: When t_we_o=0, t_o equals the sampled t_i. The flag is therefore passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 16 | Instruction word |
| rm_i | input | 32 | Source register rm value |
| rn_i | input | 32 | Source/destination register rn value |
| t_i | input | 1 | Current T flag |
| rn_o | output | 32 | Result for rn |
| rn_we_o | output | 1 | rn write-enable |
| t_o | output | 1 | New T value |
| t_we_o | output | 1 | T write-enable |
| illegal_o | output | 1 | Instruction word not in this group |

## Verification
All five results (rn_o, rn_we_o, t_o, t_we_o, illegal_o) are due exactly one rising edge after the operands are presented. The bench therefore drives each vector on a falling edge and compares on the following falling edge, halfway past the single register stage. Reset is the one exception: it is checked a short delay after rst_ni falls, with no clock edge in between, so the asynchronous clear is exercised. The bound properties use the previous cycle's inputs and are gated until one edge has passed out of reset.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;
  typedef enum logic [3:0] {
    OP_ILL,
    OP_DEC_TST,
    OP_SEXT_B,
    OP_SEXT_H,
    OP_ZEXT_B,
    OP_ZEXT_H,
    OP_NEG,
    OP_NEG_B,
    OP_SUB,
    OP_SUB_B
  } alu_op_e;
endpackage

// File: rtl/tflag_alu_dec.sv
module tflag_alu_dec
  import tflag_alu_pkg::*;
(
  input  logic [15:0] insn_i,
  output alu_op_e     op_o
);
  logic [3:0] major, minor;
  assign major = insn_i[15:12];
  assign minor = insn_i[3:0];

  always_comb begin
    op_o = OP_ILL;
    unique case (major)
      4'h4: if (insn_i[7:0] == 8'h10) op_o = OP_DEC_TST;
      4'h6: begin
        case (minor)
          4'hE: op_o = OP_SEXT_B;
          4'hF: op_o = OP_SEXT_H;
          4'hC: op_o = OP_ZEXT_B;
          4'hD: op_o = OP_ZEXT_H;
          4'hB: op_o = OP_NEG;
          4'hA: op_o = OP_NEG_B;
          default: op_o = OP_ILL;
        endcase
      end
      4'h3: begin
        case (minor)
          4'h8: op_o = OP_SUB;
          4'hA: op_o = OP_SUB_B;
          default: op_o = OP_ILL;
        endcase
      end
      default: op_o = OP_ILL;
    endcase
  end
endmodule

// File: rtl/tflag_alu_dp.sv
module tflag_alu_dp
  import tflag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic              t_o,
  output logic              t_we_o,
  output logic              ill_o
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] sub_a, sub_b;
  logic              sub_cin;
  logic [DATA_W:0]   diff;

  // single shared subtractor; bit DATA_W is the unsigned borrow
  assign diff = {1'b0, sub_a} - {1'b0, sub_b} - {{DATA_W{1'b0}}, sub_cin};

  always_comb begin
    sub_a   = rn_i;
    sub_b   = rm_i;
    sub_cin = 1'b0;
    unique case (op_i)
      OP_DEC_TST: sub_b = DATA_W'(1);
      OP_NEG:     sub_a = '0;
      OP_NEG_B: begin sub_a = '0; sub_cin = t_i; end
      OP_SUB_B:   sub_cin = t_i;
      default: ;
    endcase
  end

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b1;
    t_o      = t_i;
    t_we_o   = 1'b0;
    ill_o    = 1'b0;
    unique case (op_i)
      OP_DEC_TST: begin
        res_o  = diff[DATA_W-1:0];
        t_o    = (diff[DATA_W-1:0] == '0);
        t_we_o = 1'b1;
      end
      OP_SEXT_B: res_o = {{(DATA_W-BYTE_W){rm_i[BYTE_W-1]}}, rm_i[BYTE_W-1:0]};
      OP_SEXT_H: res_o = {{(DATA_W-HALF_W){rm_i[HALF_W-1]}}, rm_i[HALF_W-1:0]};
      OP_ZEXT_B: res_o = {{(DATA_W-BYTE_W){1'b0}}, rm_i[BYTE_W-1:0]};
      OP_ZEXT_H: res_o = {{(DATA_W-HALF_W){1'b0}}, rm_i[HALF_W-1:0]};
      OP_NEG, OP_SUB: res_o = diff[DATA_W-1:0];
      OP_NEG_B, OP_SUB_B: begin
        res_o  = diff[DATA_W-1:0];
        t_o    = diff[DATA_W];
        t_we_o = 1'b1;
      end
      default: begin
        res_we_o = 1'b0;
        ill_o    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
  import tflag_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       insn_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic              t_i,
  output logic [DATA_W-1:0] rn_o,
  output logic              rn_we_o,
  output logic              t_o,
  output logic              t_we_o,
  output logic              illegal_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] res_d;
  logic              res_we_d, t_d, t_we_d, ill_d;

  tflag_alu_dec u_dec (
    .insn_i (insn_i),
    .op_o   (op)
  );

  tflag_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .op_i     (op),
    .rm_i     (rm_i),
    .rn_i     (rn_i),
    .t_i      (t_i),
    .res_o    (res_d),
    .res_we_o (res_we_d),
    .t_o      (t_d),
    .t_we_o   (t_we_d),
    .ill_o    (ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rn_o      <= '0;
      rn_we_o   <= 1'b0;
      t_o       <= 1'b0;
      t_we_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      rn_o      <= res_d;
      rn_we_o   <= res_we_d;
      t_o       <= t_d;
      t_we_o    <= t_we_d;
      illegal_o <= ill_d;
    end
  end
endmodule

// File: rtl/tflag_alu_chk.sv
module tflag_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       insn_i,
  input logic [DATA_W-1:0] rm_i,
  input logic [DATA_W-1:0] rn_i,
  input logic              t_i,
  input logic [DATA_W-1:0] rn_o,
  input logic              rn_we_o,
  input logic              t_o,
  input logic              t_we_o,
  input logic              illegal_o
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  a_r9_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!rn_we_o && !t_we_o));

  a_r2_dec_zero_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(insn_i[15:12] == 4'h4 && insn_i[7:0] == 8'h10))
      |-> (t_we_o && rn_we_o && (t_o == (rn_o == '0))));

  a_r7_sub_keeps_t: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(insn_i[15:12] == 4'h3 && insn_i[3:0] == 4'h8))
      |-> (!t_we_o && rn_o == $past(rn_i - rm_i)));

  a_r4_zext_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(insn_i[15:12] == 4'h6 && insn_i[3:0] == 4'hC))
      |-> (rn_we_o && rn_o[DATA_W-1:8] == '0));

  a_r8_subc_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(insn_i[15:12] == 4'h3 && insn_i[3:0] == 4'hA))
      |-> (t_we_o && {t_o, rn_o} ==
           $past({1'b0, rn_i} - {1'b0, rm_i} - {{DATA_W{1'b0}}, t_i})));

  a_r11_t_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !t_we_o) |-> (t_o == $past(t_i)));
endmodule

bind tflag_alu tflag_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .insn_i    (insn_i),
  .rm_i      (rm_i),
  .rn_i      (rn_i),
  .t_i       (t_i),
  .rn_o      (rn_o),
  .rn_we_o   (rn_we_o),
  .t_o       (t_o),
  .t_we_o    (t_we_o),
  .illegal_o (illegal_o)
);

// File: tb/tflag_alu_tb.sv
module tflag_alu_tb;
  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] insn;
    logic [31:0] rm;
    logic [31:0] rn;
    logic        t;
    logic [31:0] x_rn;
    logic        x_we;
    logic        x_t;
    logic        x_twe;
    logic        x_ill;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R2 decrement-and-test
    '{4'd2, 16'h4310, 32'h0, 32'h1, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd2, 16'h4310, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd2, 16'h4A10, 32'h0, 32'h5, 1'b1, 32'h4, 1'b1, 1'b0, 1'b1, 1'b0},
    // R3 sign extension
    '{4'd3, 16'h612E, 32'h1234_5680, 32'h0, 1'b0, 32'hFFFF_FF80, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd3, 16'h612F, 32'h0001_7FFF, 32'h0, 1'b1, 32'h0000_7FFF, 1'b1, 1'b1, 1'b0, 1'b0},
    '{4'd3, 16'h612F, 32'h0000_8001, 32'h0, 1'b0, 32'hFFFF_8001, 1'b1, 1'b0, 1'b0, 1'b0},
    // R4 zero extension
    '{4'd4, 16'h612C, 32'hFFFF_FFAB, 32'h0, 1'b0, 32'h0000_00AB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd4, 16'h612D, 32'hFFFF_1234, 32'h0, 1'b1, 32'h0000_1234, 1'b1, 1'b1, 1'b0, 1'b0},
    // R5 negate, T untouched (R11)
    '{4'd5, 16'h612B, 32'h5, 32'h0, 1'b1, 32'hFFFF_FFFB, 1'b1, 1'b1, 1'b0, 1'b0},
    // R6 negate with borrow
    '{4'd6, 16'h612A, 32'h0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd6, 16'h612A, 32'h0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd6, 16'h612A, 32'h1, 32'h0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
    // R7 subtract, T untouched (R11)
    '{4'd7, 16'h3128, 32'h5, 32'h3, 1'b1, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0, 1'b0},
    // R8 subtract with borrow
    '{4'd8, 16'h312A, 32'h3, 32'h5, 1'b1, 32'h1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd8, 16'h312A, 32'h3, 32'h3, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd8, 16'h312A, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0},
    // R9 illegal words
    '{4'd9, 16'h0000, 32'h7, 32'h9, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd9, 16'h4311, 32'h7, 32'h9, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd9, 16'h3129, 32'h7, 32'h9, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] insn_i = 16'h0;
  logic [31:0] rm_i = '0, rn_i = '0;
  logic        t_i = 1'b0;
  logic [31:0] rn_o;
  logic        rn_we_o, t_o, t_we_o, illegal_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tflag_alu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .insn_i(insn_i), .rm_i(rm_i), .rn_i(rn_i),
    .t_i(t_i), .rn_o(rn_o), .rn_we_o(rn_we_o), .t_o(t_o), .t_we_o(t_we_o),
    .illegal_o(illegal_o)
  );

  task automatic check_out(input int req, input logic [31:0] e_rn, input logic e_we,
                           input logic e_t, input logic e_twe, input logic e_ill);
    checks++;
    if (rn_o !== e_rn || rn_we_o !== e_we || t_o !== e_t ||
        t_we_o !== e_twe || illegal_o !== e_ill) begin
      errors++;
      $display("FAIL R%0d: got rn=%h we=%b t=%b twe=%b ill=%b exp rn=%h we=%b t=%b twe=%b ill=%b",
               req, rn_o, rn_we_o, t_o, t_we_o, illegal_o, e_rn, e_we, e_t, e_twe, e_ill);
    end
  endtask

  initial begin
    #1;
    check_out(10, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0); // R10 reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: one-cycle latency for each vector
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      insn_i = VECS[i].insn; rm_i = VECS[i].rm; rn_i = VECS[i].rn; t_i = VECS[i].t;
      @(negedge clk_i);
      check_out(int'(VECS[i].req), VECS[i].x_rn, VECS[i].x_we, VECS[i].x_t,
                VECS[i].x_twe, VECS[i].x_ill);
    end
    // R1: back-to-back, result follows each edge
    @(negedge clk_i);
    insn_i = 16'h3128; rm_i = 32'h1; rn_i = 32'h10; t_i = 1'b0;
    @(negedge clk_i);
    check_out(1, 32'hF, 1'b1, 1'b0, 1'b0, 1'b0);
    insn_i = 16'h612C; rm_i = 32'h1FF;
    @(negedge clk_i);
    check_out(1, 32'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10: asynchronous clear mid-run
    insn_i = 16'h4310; rn_i = 32'h1; t_i = 1'b1;
    @(negedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check_out(10, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out(2, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule